// File: doc/BRIEF.md
# Ordered Store Buffer with Fence Entries

This block holds a single core's executed stores between execution and the data cache. Each accepted entry is a regular store, a non-temporal store, a store-ordering fence or a full memory fence. Both fence kinds are written into the buffer as entries. They do not stall the pipeline. Entries become retired in allocation order, one per retire pulse. Retired stores drain by themselves to a simple cache write port that uses a valid/ready handshake. No fence is needed to start the draining.

Loads query the block every cycle. A load is treated as younger than every entry the buffer holds. If any full fence is present, the block denies the load permission. Otherwise it may supply forwarded data from a matching regular store. A flush input removes every entry that is not yet retired, so speculative work can be undone. Retired entries stay and still commit.

Regular stores reach the cache in program order. A store-ordering fence only keeps non-temporal stores behind it from overtaking the stores ahead of it. A non-temporal store with no fence ahead of it is given priority and may commit before older regular stores.

Top module: `sb_store_buffer`

## Requirements
- R1: After reset the buffer is empty: `alloc_full` is 0, `cm_valid` is 0, and a valid load is granted with no forward hit.
- R2: An entry that has not retired is never offered on the commit port. Kind codes on `alloc_kind` are 0 for a regular store, 1 for a non-temporal store, 2 for a store fence and 3 for a full fence.
- R3: Regular stores are offered on the commit port in allocation order. One entry commits per cycle in which `cm_valid` and `cm_ready` are both 1.
- R4: While a full fence (kind 3) sits anywhere in the buffer, `ld_grant` is 0. The fence leaves one cycle after it is both retired and at the head, which is after every older store has committed. From then on loads are granted.
- R5: When `flush_valid` is high, every entry still unretired after that cycle's retire pulse is discarded and retired entries stay. An allocation presented in that cycle is ignored.
- R6: A granted load gets `ld_fwd_hit` together with the data of the youngest regular store (kind 0) whose address and size code both equal the load's. Non-temporal stores and partial matches give no hit.
- R7: A store fence (kind 2) does not deny loads. A retired non-temporal store behind it is not offered on the commit port until the fence has left the head.
- R8: A retired, uncommitted non-temporal store with no fence ahead of it is offered on the commit port before older retired regular stores, and `cm_nt` is 1 for it.
- R9: `alloc_full` is 1 exactly when DEPTH entries are held. An allocation presented while full is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| alloc_valid | input | 1 | Allocate one executed entry |
| alloc_kind | input | 2 | Entry kind code |
| alloc_addr | input | 16 | Store address |
| alloc_data | input | 32 | Store data |
| alloc_size | input | 2 | Store size code |
| alloc_full | output | 1 | No free entry; allocation must stall |
| retire_valid | input | 1 | Retire the oldest unretired entry |
| flush_valid | input | 1 | Discard all unretired entries |
| cm_valid | output | 1 | A store is offered to the cache |
| cm_ready | input | 1 | Cache accepts the offered store |
| cm_addr | output | 16 | Offered store address |
| cm_data | output | 32 | Offered store data |
| cm_size | output | 2 | Offered store size code |
| cm_nt | output | 1 | Offered store is non-temporal |
| ld_valid | input | 1 | Load permission query |
| ld_addr | input | 16 | Load address |
| ld_size | input | 2 | Load size code |
| ld_grant | output | 1 | Load may proceed |
| ld_fwd_hit | output | 1 | Forwarded data is valid |
| ld_fwd_data | output | 32 | Forwarded data |

## Verification
A flush can arrive in the same cycle as a retire pulse. The block has to apply the retire first, so the entry retired in that cycle survives while its younger neighbour is discarded. The bench raises both inputs on one edge, with an allocation also pending, and then checks three things at the ports: the survivor is offered on the commit port, it still forwards, and neither the discarded store nor the dropped allocation forwards. A similar collision between a commit and a fence becoming the head is checked through `ld_grant` on the two cycles that follow.

// File: rtl/sb_pkg.sv
// Shared types for the store buffer.
package sb_pkg;
    localparam int SB_ADDR_W = 16;
    localparam int SB_DATA_W = 32;

    typedef enum logic [1:0] {
        SB_REG    = 2'd0,
        SB_NT     = 2'd1,
        SB_SFENCE = 2'd2,
        SB_MFENCE = 2'd3
    } sb_kind_e;

    typedef struct packed {
        sb_kind_e               kind;
        logic [SB_ADDR_W-1:0]   addr;
        logic [SB_DATA_W-1:0]   data;
        logic [1:0]             size;
        logic                   done;
    } sb_entry_t;

    function automatic logic sb_is_fence(sb_kind_e k);
        return (k == SB_SFENCE) || (k == SB_MFENCE);
    endfunction
endpackage

// File: rtl/sb_ptr_ctrl.sv
// Occupancy control: head pointer, held count and retired count.
// Assumes retirement is in allocation order and that pops only remove
// retired entries at the head.
module sb_ptr_ctrl #(
    parameter int DEPTH = 8,
    localparam int PW = $clog2(DEPTH),
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          alloc_req,
    input  logic          retire_req,
    input  logic          flush,
    input  logic          pop,
    output logic          alloc_fire,
    output logic          retire_fire,
    output logic          full,
    output logic [PW-1:0] head,
    output logic [PW-1:0] alloc_idx,
    output logic [CW-1:0] count,
    output logic [CW-1:0] ret_cnt
);
    logic [CW-1:0] ret_next;

    // Accept/retire decisions from current occupancy.
    always_comb begin
        full        = (count == CW'(DEPTH));
        alloc_fire  = alloc_req && !full && !flush;
        retire_fire = retire_req && (ret_cnt < count);
        alloc_idx   = head + PW'(count);
        ret_next    = ret_cnt + CW'(retire_fire) - CW'(pop);
    end

    // Pointer and counter update; flush trims to the retired part.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head    <= '0;
            count   <= '0;
            ret_cnt <= '0;
        end else begin
            head    <= head + PW'(pop);
            ret_cnt <= ret_next;
            if (flush)
                count <= ret_next;
            else
                count <= count + CW'(alloc_fire) - CW'(pop);
        end
    end
endmodule

// File: rtl/sb_commit_sel.sv
// Chooses the entry offered to the cache and decides whether the head
// leaves this cycle. Assumes entries [0, ret_cnt) from head are retired.
module sb_commit_sel
    import sb_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int PW = $clog2(DEPTH),
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  sb_entry_t     ent [DEPTH],
    input  logic [PW-1:0] head,
    input  logic [CW-1:0] ret_cnt,
    input  logic          cm_ready,
    output logic          sel_valid,
    output logic [PW-1:0] sel_idx,
    output logic          pop
);
    logic          nt_found;
    logic [PW-1:0] nt_idx;
    logic          fence_seen;
    logic          head_store;
    logic [PW-1:0] idx;

    // Oldest retired non-temporal store with no fence ahead of it.
    always_comb begin
        nt_found   = 1'b0;
        nt_idx     = '0;
        fence_seen = 1'b0;
        idx        = '0;
        for (int k = 0; k < DEPTH; k++) begin
            idx = head + PW'(k);
            if (CW'(k) < ret_cnt) begin
                if (!fence_seen && !nt_found && ent[idx].kind == SB_NT && !ent[idx].done) begin
                    nt_found = 1'b1;
                    nt_idx   = idx;
                end
                if (sb_is_fence(ent[idx].kind))
                    fence_seen = 1'b1;
            end
        end
    end

    // Selection priority and head removal.
    always_comb begin
        head_store = (ret_cnt != '0) && !sb_is_fence(ent[head].kind) && !ent[head].done;
        sel_valid  = nt_found || head_store;
        sel_idx    = nt_found ? nt_idx : head;
        pop        = (ret_cnt != '0) &&
                     (ent[head].done || sb_is_fence(ent[head].kind) ||
                      (sel_valid && sel_idx == head && cm_ready));
    end
endmodule

// File: rtl/sb_load_gate.sv
// Load permission and store-to-load forwarding. Assumes the querying
// load is younger than every entry currently held.
module sb_load_gate
    import sb_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int PW = $clog2(DEPTH),
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  sb_entry_t             ent [DEPTH],
    input  logic [PW-1:0]         head,
    input  logic [CW-1:0]         count,
    input  logic                  ld_valid,
    input  logic [SB_ADDR_W-1:0]  ld_addr,
    input  logic [1:0]            ld_size,
    output logic                  ld_grant,
    output logic                  ld_fwd_hit,
    output logic [SB_DATA_W-1:0]  ld_fwd_data
);
    logic                 fence_any;
    logic                 hit;
    logic [SB_DATA_W-1:0] hit_data;
    logic [PW-1:0]        idx;

    // Scan oldest to youngest; the last match is the youngest.
    always_comb begin
        fence_any = 1'b0;
        hit       = 1'b0;
        hit_data  = '0;
        idx       = '0;
        for (int k = 0; k < DEPTH; k++) begin
            idx = head + PW'(k);
            if (CW'(k) < count) begin
                if (ent[idx].kind == SB_MFENCE)
                    fence_any = 1'b1;
                if (ent[idx].kind == SB_REG && !ent[idx].done &&
                    ent[idx].addr == ld_addr && ent[idx].size == ld_size) begin
                    hit      = 1'b1;
                    hit_data = ent[idx].data;
                end
            end
        end
    end

    // Output gating by permission.
    always_comb begin
        ld_grant    = ld_valid && !fence_any;
        ld_fwd_hit  = ld_grant && hit;
        ld_fwd_data = ld_fwd_hit ? hit_data : '0;
    end
endmodule

// File: rtl/sb_store_buffer.sv
// Ordered store buffer with fence entries. Holds the entry array and
// connects occupancy control, commit selection and the load gate.
// Assumes in-order retirement and at most one commit per clock.
module sb_store_buffer
    import sb_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int PW = $clog2(DEPTH),
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 alloc_valid,
    input  logic [1:0]           alloc_kind,
    input  logic [SB_ADDR_W-1:0] alloc_addr,
    input  logic [SB_DATA_W-1:0] alloc_data,
    input  logic [1:0]           alloc_size,
    output logic                 alloc_full,
    input  logic                 retire_valid,
    input  logic                 flush_valid,
    output logic                 cm_valid,
    input  logic                 cm_ready,
    output logic [SB_ADDR_W-1:0] cm_addr,
    output logic [SB_DATA_W-1:0] cm_data,
    output logic [1:0]           cm_size,
    output logic                 cm_nt,
    input  logic                 ld_valid,
    input  logic [SB_ADDR_W-1:0] ld_addr,
    input  logic [1:0]           ld_size,
    output logic                 ld_grant,
    output logic                 ld_fwd_hit,
    output logic [SB_DATA_W-1:0] ld_fwd_data
);
    sb_entry_t     ent [DEPTH];
    logic          alloc_fire;
    logic          retire_fire;
    logic [PW-1:0] head;
    logic [PW-1:0] alloc_idx;
    logic [CW-1:0] count;
    logic [CW-1:0] ret_cnt;
    logic          sel_valid;
    logic [PW-1:0] sel_idx;
    logic          pop;

    sb_ptr_ctrl #(.DEPTH(DEPTH)) ptr_i (
        .clk(clk), .rst_n(rst_n),
        .alloc_req(alloc_valid), .retire_req(retire_valid),
        .flush(flush_valid), .pop(pop),
        .alloc_fire(alloc_fire), .retire_fire(retire_fire), .full(alloc_full),
        .head(head), .alloc_idx(alloc_idx), .count(count), .ret_cnt(ret_cnt)
    );

    sb_commit_sel #(.DEPTH(DEPTH)) sel_i (
        .ent(ent), .head(head), .ret_cnt(ret_cnt), .cm_ready(cm_ready),
        .sel_valid(sel_valid), .sel_idx(sel_idx), .pop(pop)
    );

    sb_load_gate #(.DEPTH(DEPTH)) ld_i (
        .ent(ent), .head(head), .count(count),
        .ld_valid(ld_valid), .ld_addr(ld_addr), .ld_size(ld_size),
        .ld_grant(ld_grant), .ld_fwd_hit(ld_fwd_hit), .ld_fwd_data(ld_fwd_data)
    );

    // Commit port drive from the selected entry.
    always_comb begin
        cm_valid = sel_valid;
        cm_addr  = ent[sel_idx].addr;
        cm_data  = ent[sel_idx].data;
        cm_size  = ent[sel_idx].size;
        cm_nt    = sel_valid && (ent[sel_idx].kind == SB_NT);
    end

    // Entry array: write on allocation, mark done on commit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++)
                ent[i] <= '0;
        end else begin
            if (alloc_fire)
                ent[alloc_idx] <= '{kind: sb_kind_e'(alloc_kind), addr: alloc_addr,
                                    data: alloc_data, size: alloc_size, done: 1'b0};
            if (sel_valid && cm_ready)
                ent[sel_idx].done <= 1'b1;
        end
    end
endmodule

// File: rtl/sb_store_buffer_chk.sv
// Assertion checker for sb_store_buffer, attached by bind.
module sb_store_buffer_chk #(
    parameter int DEPTH = 8,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cm_valid,
    input logic          alloc_full,
    input logic          flush_valid,
    input logic          pop,
    input logic          ld_valid,
    input logic          ld_grant,
    input logic          ld_fwd_hit,
    input logic [CW-1:0] count,
    input logic [CW-1:0] ret_cnt
);
    // R2: something is offered only while retired entries exist
    a_r2_commit_retired: assert property (@(posedge clk) disable iff (!rst_n)
        cm_valid |-> (ret_cnt != '0));

    // R9: a full buffer stays full unless an entry leaves
    a_r9_full_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_full && !pop && !flush_valid) |=> alloc_full);

    // R4: a denying fence can only disappear through a pop or a flush
    a_r4_fence_persist: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_valid && !ld_grant && !pop && !flush_valid) |=> (!ld_valid || !ld_grant));

    // R5: after a flush every held entry is retired
    a_r5_flush_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        flush_valid |=> (count == ret_cnt));

    // R6: forwarding only for a granted load
    a_r6_fwd_needs_grant: assert property (@(posedge clk) disable iff (!rst_n)
        ld_fwd_hit |-> ld_grant);
endmodule

bind sb_store_buffer sb_store_buffer_chk #(.DEPTH(DEPTH)) chk_i (
    .clk(clk), .rst_n(rst_n), .cm_valid(cm_valid), .alloc_full(alloc_full),
    .flush_valid(flush_valid), .pop(pop), .ld_valid(ld_valid), .ld_grant(ld_grant),
    .ld_fwd_hit(ld_fwd_hit), .count(count), .ret_cnt(ret_cnt)
);

// File: tb/sb_store_buffer_tb_top.sv
// Self-checking bench for sb_store_buffer.
module sb_store_buffer_tb_top;
    localparam int DEPTH = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        alloc_valid = 1'b0;
    logic [1:0]  alloc_kind = 2'd0;
    logic [15:0] alloc_addr = '0;
    logic [31:0] alloc_data = '0;
    logic [1:0]  alloc_size = 2'd0;
    logic        alloc_full;
    logic        retire_valid = 1'b0;
    logic        flush_valid = 1'b0;
    logic        cm_valid;
    logic        cm_ready = 1'b0;
    logic [15:0] cm_addr;
    logic [31:0] cm_data;
    logic [1:0]  cm_size;
    logic        cm_nt;
    logic        ld_valid = 1'b1;
    logic [15:0] ld_addr = '0;
    logic [1:0]  ld_size = 2'd2;
    logic        ld_grant;
    logic        ld_fwd_hit;
    logic [31:0] ld_fwd_data;

    int checks = 0;
    int errors = 0;

    // Load query vectors: {addr, size, expected hit, expected data}
    localparam logic [50:0] LD_VEC [5] = '{
        {16'h0010, 2'd2, 1'b1, 32'd33},
        {16'h0020, 2'd2, 1'b1, 32'd22},
        {16'h0020, 2'd1, 1'b0, 32'd0},
        {16'h0030, 2'd2, 1'b0, 32'd0},
        {16'h0040, 2'd2, 1'b0, 32'd0}
    };

    always #10 clk = ~clk;

    sb_store_buffer #(.DEPTH(DEPTH)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .alloc_valid(alloc_valid), .alloc_kind(alloc_kind), .alloc_addr(alloc_addr),
        .alloc_data(alloc_data), .alloc_size(alloc_size), .alloc_full(alloc_full),
        .retire_valid(retire_valid), .flush_valid(flush_valid),
        .cm_valid(cm_valid), .cm_ready(cm_ready), .cm_addr(cm_addr), .cm_data(cm_data),
        .cm_size(cm_size), .cm_nt(cm_nt),
        .ld_valid(ld_valid), .ld_addr(ld_addr), .ld_size(ld_size),
        .ld_grant(ld_grant), .ld_fwd_hit(ld_fwd_hit), .ld_fwd_data(ld_fwd_data)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic put(input logic [1:0] kind, input logic [15:0] a, input logic [31:0] d);
        alloc_valid = 1'b1; alloc_kind = kind; alloc_addr = a; alloc_data = d; alloc_size = 2'd2;
        tick();
        alloc_valid = 1'b0;
    endtask

    task automatic retire(input int n);
        for (int i = 0; i < n; i++) begin
            retire_valid = 1'b1;
            tick();
        end
        retire_valid = 1'b0;
    endtask

    task automatic drain();
        retire_valid = 1'b1; cm_ready = 1'b1;
        repeat (3 * DEPTH) tick();
        retire_valid = 1'b0; cm_ready = 1'b0;
    endtask

    task automatic query(input logic [15:0] a, input logic [1:0] s);
        ld_addr = a; ld_size = s;
        #1;
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        #(20 * 100000);
        errors++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        tick();

        // R1 reset state
        query(16'h0010, 2'd2);
        check("R1 full", alloc_full, 0);
        check("R1 cm_valid", cm_valid, 0);
        check("R1 grant", ld_grant, 1);
        check("R1 fwd", ld_fwd_hit, 0);

        // R6 forwarding table over unretired stores; R2 nothing offered
        put(2'd0, 16'h0010, 32'd11);
        put(2'd0, 16'h0020, 32'd22);
        put(2'd0, 16'h0010, 32'd33);
        put(2'd1, 16'h0030, 32'd44);
        check("R2 unretired not offered", cm_valid, 0);
        foreach (LD_VEC[i]) begin
            query(LD_VEC[i][50:35], LD_VEC[i][34:33]);
            check("R6 hit", ld_fwd_hit, LD_VEC[i][32]);
            check("R6 data", ld_fwd_data, LD_VEC[i][31:0]);
        end

        // R8 NT first, then R3 regular stores in order
        retire(4);
        check("R8 nt first addr", cm_addr, 32'h30);
        check("R8 nt flag", cm_nt, 1);
        cm_ready = 1'b1;
        tick();
        check("R3 first", cm_data, 11);
        check("R3 not nt", cm_nt, 0);
        tick();
        check("R3 second", cm_data, 22);
        tick();
        check("R3 third", cm_data, 33);
        tick();
        check("R3 empty", cm_valid, 0);
        cm_ready = 1'b0;

        // R4 full fence blocks loads until it leaves the head
        put(2'd0, 16'h0050, 32'd55);
        put(2'd3, 16'h0000, 32'd0);
        query(16'h0050, 2'd2);
        check("R4 denied", ld_grant, 0);
        check("R4 no fwd while denied", ld_fwd_hit, 0);
        retire(2);
        check("R4 denied after retire", ld_grant, 0);
        cm_ready = 1'b1;
        tick();
        check("R4 fence at head still denies", ld_grant, 0);
        tick();
        check("R4 granted after fence left", ld_grant, 1);
        cm_ready = 1'b0;

        // R7 store fence: loads allowed, NT held behind it
        put(2'd0, 16'h0060, 32'd66);
        put(2'd2, 16'h0000, 32'd0);
        put(2'd1, 16'h0070, 32'd77);
        query(16'h0060, 2'd2);
        check("R7 grant", ld_grant, 1);
        check("R7 fwd", ld_fwd_data, 66);
        retire(3);
        check("R7 older regular first", cm_addr, 32'h60);
        cm_ready = 1'b1;
        tick();
        check("R7 nothing while fence at head", cm_valid, 0);
        tick();
        check("R7 nt after fence", cm_addr, 32'h70);
        check("R7 nt flag", cm_nt, 1);
        tick();
        cm_ready = 1'b0;

        // R9 full and dropped allocation
        for (int i = 0; i < DEPTH; i++) put(2'd0, 16'h0100 + 16'(i), 32'(i));
        check("R9 full", alloc_full, 1);
        put(2'd0, 16'h01FF, 32'hDEAD);
        query(16'h01FF, 2'd2);
        check("R9 extra dropped", ld_fwd_hit, 0);
        query(16'h0107, 2'd2);
        check("R9 last kept", ld_fwd_data, 7);
        drain();
        check("R9 empty after drain", alloc_full, 0);

        // R5 flush in the same cycle as a retire and an allocation
        put(2'd0, 16'h0200, 32'd1);
        put(2'd0, 16'h0204, 32'd2);
        retire_valid = 1'b1; flush_valid = 1'b1;
        alloc_valid = 1'b1; alloc_kind = 2'd0; alloc_addr = 16'h0208; alloc_data = 32'd3;
        tick();
        retire_valid = 1'b0; flush_valid = 1'b0; alloc_valid = 1'b0;
        check("R5 retired kept offered", cm_addr, 32'h200);
        query(16'h0200, 2'd2);
        check("R5 retired still forwards", ld_fwd_data, 1);
        query(16'h0204, 2'd2);
        check("R5 unretired gone", ld_fwd_hit, 0);
        query(16'h0208, 2'd2);
        check("R5 alloc in flush dropped", ld_fwd_hit, 0);
        drain();
        check("R5 drained", cm_valid, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule